// File: doc/BRIEF.md
# Host Register File with Interrupt Status Aggregation

This block is the host-facing register file of a bus controller. An 8-bit host reaches it through an active-low select, a 5-bit register address and separate active-low read and write strobes. Internal engines report events as one-cycle pulses. Each pulse sets a bit in one of two detailed status registers. The block drives an active-low interrupt request whenever an enabled status bit is pending.

On an interrupt the host first reads the summary register, which names the status register that holds the cause. It then reads that status register and writes the same value back. A write-back clears exactly the bits that were read as set. Bits raised later by new events are left alone. The block also holds a 3-bit device ID and an 8-bit mode register. One mode bit hands the data bus to direct host control, with signal states kept active high.

Write strobes are handled by a small access state machine. It has two states:
- `ST_IDLE`: the machine waits for a write. A selected, low write strobe commits the write on that clock edge and takes the transition *commit* to `ST_WR_HOLD`.
- `ST_WR_HOLD`: the machine holds while the strobe stays low. When the strobe or the select goes high, it takes the transition *release* back to `ST_IDLE`.

Reads are sampled on every clock edge while a read is selected.

Top module: `hri_regfile`

## Requirements
- R1: With `cs_n` high, no write takes effect, and `rdata` is 0 on the cycle after the edge.
- R2: At a clock edge where `cs_n` and `rd_n` are low and `wr_n` is high, the addressed register's value is captured. It appears on `rdata` from that edge until the next edge. At every other edge `rdata` becomes 0.
- R3: Each low period of `wr_n` under select commits exactly one write, on its first clock edge. If both strobes are low, the write is performed and `rdata` is 0.
- R4: An event pulse sets its status bit at the next clock edge. `evt[7:0]` feeds status register A at address 1, and `evt[15:8]` feeds status register B at address 2.
- R5: A write to a status register clears the bits where `wdata` is 1. Bits where `wdata` is 0 are unchanged.
- R6: If an event and a write-back clear hit the same bit in the same cycle, the bit stays set.
- R7: The summary register at address 0 is read-only. Bit 0 is 1 when register A has a set bit whose enable is 1. Bit 1 is the same for register B. Bits 7:2 read 0.
- R8: The enable registers at address 3 (for A) and address 4 (for B) reset to 0xFF. An enable bit of 1 lets the matching status bit count toward the summary and the interrupt. Status bits are kept whether or not they are enabled.
- R9: `irq_n` goes low one clock after an enabled status bit becomes set. It goes high one clock after the last enabled set bit clears or is disabled.
- R10: The ID register at address 5 stores `wdata[2:0]` and drives `own_id`. Bits 7:3 read 0.
- R11: The mode register at address 6 stores 8 bits and drives `mode`. Bit 1 drives `direct_en`: 1 means the data bus is under direct host control, with states active high.
- R12: Addresses 7 to 31 read 0 and ignore writes. Reset clears every register except the enables, and leaves `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Register select, active low |
| addr | input | 5 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data |
| evt | input | 16 | Event pulses; [7:0] to status A, [15:8] to status B |
| rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Interrupt request, active low |
| own_id | output | 3 | Stored device ID |
| mode | output | 8 | Stored mode register |
| direct_en | output | 1 | Direct data-bus control enable (mode bit 1) |

## Verification
Each result has a fixed due time:
- Read data is due at the clock edge that samples the strobe.
- A status bit, an enable, the ID and the mode all change at the edge that commits the event or write.
- `irq_n` follows one edge later than the status or enable change.

The bench drives inputs just after a rising edge and queues each expected value for the cycle in which it is due. A monitor compares the queued values at the falling edge. So an `irq_n` check made right after a commit still expects the old level, and the check one edge later expects the new level.

// File: rtl/hri_pkg.sv
package hri_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_WR_HOLD = 1'b1
    } acc_state_e;
endpackage

// File: rtl/hri_access_fsm.sv
module hri_access_fsm
    import hri_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_fire,
    output logic rd_fire
);
    acc_state_e state_q, state_d;
    logic       wr_act;

    assign wr_act = !cs_n && !wr_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (wr_act)  state_d = ST_WR_HOLD;
            ST_WR_HOLD: if (!wr_act) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_fire = (state_q == ST_IDLE) && wr_act;
        rd_fire = !cs_n && !rd_n && wr_n;
    end

    // R3: a held strobe never commits twice in a row
    a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);
    // R1: no commit without select
    a_r1_no_write_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !wr_fire);
endmodule

// File: rtl/hri_status_bank.sv
module hri_status_bank #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt,
    input  logic          clr_en,
    input  logic          en_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] stat,
    output logic [DW-1:0] enable,
    output logic          pending
);
    logic [DW-1:0] clr_mask;

    assign clr_mask = clr_en ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat   <= '0;
            enable <= '1;
        end else begin
            stat <= (stat & ~clr_mask) | evt;
            if (en_we) enable <= wdata;
        end
    end

    assign pending = |(stat & enable);

    // R4: every pulsed bit is set after the edge
    a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));
    // R5: written ones without a colliding event are cleared
    a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((stat & $past(wdata & ~evt)) == '0));
    // R6: collision keeps the bit set
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && ((evt & wdata) != '0)) |=> ((stat & $past(evt & wdata)) == $past(evt & wdata)));
    // R5: with no clear and no event, status is stable
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && evt == '0) |=> $stable(stat));
endmodule

// File: rtl/hri_regfile.sv
module hri_regfile #(
    parameter int DW        = 8,
    parameter int AW        = 5,
    parameter int NUM_BANKS = 2,
    parameter int IDW       = 3,
    parameter int DIRECT_BIT = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic [4:0]              addr,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic [7:0]              wdata,
    input  logic [15:0]             evt,
    output logic [7:0]              rdata,
    output logic                    irq_n,
    output logic [2:0]              own_id,
    output logic [7:0]              mode,
    output logic                    direct_en
);
    localparam int SUM_ADDR  = 0;
    localparam int STAT_BASE = 1;
    localparam int EN_BASE   = STAT_BASE + NUM_BANKS;
    localparam int ID_ADDR   = EN_BASE + NUM_BANKS;
    localparam int MODE_ADDR = ID_ADDR + 1;

    logic                 wr_fire, rd_fire;
    logic [DW-1:0]        stat_arr [NUM_BANKS];
    logic [DW-1:0]        en_arr   [NUM_BANKS];
    logic [NUM_BANKS-1:0] pend_vec;
    logic [IDW-1:0]       id_q;
    logic [DW-1:0]        mode_q;
    logic [DW-1:0]        rd_mux;
    logic [DW-1:0]        rdata_q;
    logic                 irq_n_q;

    hri_access_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .wr_fire (wr_fire),
        .rd_fire (rd_fire)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [AW-1:0] A_ST = AW'(STAT_BASE + g);
        localparam logic [AW-1:0] A_EN = AW'(EN_BASE + g);
        hri_status_bank #(.DW(DW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt[g*DW +: DW]),
            .clr_en  (wr_fire && addr == A_ST),
            .en_we   (wr_fire && addr == A_EN),
            .wdata   (wdata),
            .stat    (stat_arr[g]),
            .enable  (en_arr[g]),
            .pending (pend_vec[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= '0;
            mode_q <= '0;
        end else if (wr_fire) begin
            if (addr == AW'(ID_ADDR))   id_q   <= wdata[IDW-1:0];
            if (addr == AW'(MODE_ADDR)) mode_q <= wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr == AW'(SUM_ADDR))  rd_mux = DW'(pend_vec);
        if (addr == AW'(ID_ADDR))   rd_mux = DW'(id_q);
        if (addr == AW'(MODE_ADDR)) rd_mux = mode_q;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (addr == AW'(STAT_BASE + i)) rd_mux = stat_arr[i];
            if (addr == AW'(EN_BASE + i))   rd_mux = en_arr[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_n_q <= 1'b1;
        end else begin
            rdata_q <= rd_fire ? rd_mux : '0;
            irq_n_q <= ~(|pend_vec);
        end
    end

    assign rdata     = rdata_q;
    assign irq_n     = irq_n_q;
    assign own_id    = id_q;
    assign mode      = mode_q;
    assign direct_en = mode_q[DIRECT_BIT];

    // R2: no read strobe, zero data next cycle
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> (rdata == '0));
    // R9: a pending bank pulls the request low one clock later
    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec != '0) |=> !irq_n);
    // R9: nothing pending releases the request one clock later
    a_r9_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec == '0) |=> irq_n);
    // R12: reserved reads return zero
    a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && addr > AW'(MODE_ADDR)) |=> (rdata == '0));
    // R11: mode only changes on a committed write to its address
    a_r11_mode_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && addr == AW'(MODE_ADDR)) |=> $stable(mode));
endmodule

// File: tb/hri_regfile_bench.sv
`timescale 1ns/1ps
module hri_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [15:0] evt = '0;
    logic [7:0]  rdata;
    logic        irq_n;
    logic [2:0]  own_id;
    logic [7:0]  mode;
    logic        direct_en;

    int    n_vec = 0;
    int    n_bad = 0;
    int    q_kind [$];
    int    q_val  [$];
    string q_tag  [$];
    bit    done = 0;

    always #2.5 clk = ~clk;

    hri_regfile u_hri_regfile (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd_n(rd_n),
        .wr_n(wr_n), .wdata(wdata), .evt(evt), .rdata(rdata), .irq_n(irq_n),
        .own_id(own_id), .mode(mode), .direct_en(direct_en)
    );

    // monitor: pops expected items at the falling edge
    always @(negedge clk) begin
        while (q_kind.size() > 0) begin
            int k, e, a;
            string t;
            k = q_kind.pop_front();
            e = q_val.pop_front();
            t = q_tag.pop_front();
            case (k)
                0: a = int'(rdata);
                1: a = int'(irq_n);
                2: a = int'(own_id);
                default: a = int'(direct_en);
            endcase
            n_vec++;
            if (a != e) begin
                n_bad++;
                $display("FAIL %s: got 0x%0h expected 0x%0h", t, a, e);
            end
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic want(input int k, input int v, input string t);
        q_kind.push_back(k);
        q_val.push_back(v);
        q_tag.push_back(t);
    endtask

    task automatic rd(input int a, input int e, input string t);
        cs_n = 1'b0; rd_n = 1'b0; addr = 5'(a);
        tick;
        want(0, e, t);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic wr(input int a, input int d);
        cs_n = 1'b0; wr_n = 1'b0; addr = 5'(a); wdata = 8'(d);
        tick;
        cs_n = 1'b1; wr_n = 1'b1;
        tick;
    endtask

    task automatic pulse(input logic [15:0] e);
        evt = e;
        tick;
        evt = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        // R12 reset state
        want(1, 1, "R12 irq_n after reset");
        want(3, 0, "R12 direct_en after reset");
        rd(0, 0, "R7 summary reset");
        rd(1, 0, "R4 status A reset");
        rd(3, 8'hFF, "R8 enable A reset");
        rd(4, 8'hFF, "R8 enable B reset");
        rd(5, 0, "R10 id reset");
        rd(6, 0, "R11 mode reset");

        // R4/R9 event into status A
        evt = 16'h0009;
        tick;
        want(1, 1, "R9 irq_n not yet low");
        evt = '0;
        tick;
        want(1, 0, "R9 irq_n low one clock after set");
        rd(0, 1, "R7 summary points at A");
        rd(1, 8'h09, "R4 status A bits");

        // R5/R9 write-back clear
        cs_n = 1'b0; wr_n = 1'b0; addr = 5'd1; wdata = 8'h09;
        tick;
        want(1, 0, "R9 irq_n held at clear edge");
        cs_n = 1'b1; wr_n = 1'b1;
        tick;
        want(1, 1, "R9 irq_n released after clear");
        rd(1, 0, "R5 status A cleared");
        rd(0, 0, "R7 summary clear");

        // R5 partial clear on B
        pulse(16'h0600);
        wr(2, 8'h02);
        rd(2, 8'h04, "R5 partial clear");
        rd(0, 2, "R7 summary points at B");

        // R6 set wins
        cs_n = 1'b0; wr_n = 1'b0; addr = 5'd2; wdata = 8'h04; evt = 16'h0400;
        tick;
        evt = '0; cs_n = 1'b1; wr_n = 1'b1;
        tick;
        rd(2, 8'h04, "R6 set beats clear");

        // R8 enables
        wr(4, 8'h00);
        want(1, 1, "R8 disabled bit releases irq");
        rd(0, 0, "R8 summary ignores disabled");
        rd(2, 8'h04, "R8 status kept while disabled");
        wr(4, 8'hFF);
        want(1, 0, "R8 re-enable asserts irq");
        wr(2, 8'h04);
        want(1, 1, "R9 irq_n high after B clear");

        // R12 reserved and read-only
        wr(7, 8'hAA);
        wr(31, 8'h55);
        wr(0, 8'hFF);
        rd(7, 0, "R12 address 7 reads zero");
        rd(31, 0, "R12 address 31 reads zero");
        rd(0, 0, "R12 summary not writable");
        rd(6, 0, "R12 mode untouched by reserved writes");

        // R10 id
        wr(5, 8'hFD);
        rd(5, 8'h05, "R10 id low bits only");
        want(2, 5, "R10 own_id port");

        // R11 mode
        wr(6, 8'h02);
        rd(6, 8'h02, "R11 mode readback");
        want(3, 1, "R11 direct_en set");

        // R1 unselected access
        cs_n = 1'b1; rd_n = 1'b0; addr = 5'd6;
        tick;
        want(0, 0, "R1 read without select");
        rd_n = 1'b1; wr_n = 1'b0; wdata = 8'h00;
        tick;
        tick;
        wr_n = 1'b1;
        tick;
        rd(6, 8'h02, "R1 write without select ignored");

        // R3 single commit on held strobe
        cs_n = 1'b0; wr_n = 1'b0; addr = 5'd1; wdata = 8'h01;
        tick;
        evt = 16'h0001;
        tick;
        evt = '0;
        tick;
        tick;
        cs_n = 1'b1; wr_n = 1'b1;
        tick;
        rd(1, 8'h01, "R3 held strobe commits once");
        wr(1, 8'h01);
        rd(1, 8'h00, "R5 clear after held strobe");

        // R3 both strobes low
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 5'd6; wdata = 8'h40;
        tick;
        want(0, 0, "R3 both strobes give zero data");
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        tick;
        rd(6, 8'h40, "R3 write applied with both strobes");
        want(3, 0, "R11 direct_en cleared");

        tick;
        @(negedge clk);
        #1;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule